// File: doc/BRIEF.md
# Doorbell Mailbox Command Dispatcher

The dispatcher sits behind a small word-addressed register window. Host software writes a command word, holding an 8-bit command group, an 8-bit command index within the group and a 16-bit input payload length. It fills the shared payload buffer and then sets the doorbell bit. The block joins group and index into a 16-bit opcode and looks it up in a fixed table of supported commands. It also checks that the supplied length equals the length the table fixes for that opcode.

Commands that pass both checks go to an external handler through a start/done handshake. The handler can read and write the payload buffer while it runs. Commands that fail are answered by the dispatcher itself. Either way, the block then writes the return code into the status word and rewrites the command word so that only the output length remains. As the final step it drops the doorbell, which tells the host that the result can be read.

Top module: `mbox_dispatch`

## Requirements
- R1: The command word (word address 1) holds the command index in bits [7:0], the command group in bits [15:8] and the input length in bytes in bits [31:16]. The opcode is group*256 + index. The supported opcodes and their required input lengths are: 0x0100 (1), 0x0101 (2), 0x0102 (0), 0x0103 (4), 0x0300 (0), 0x0301 (8), 0x0400 (0), 0x0401 (24), 0x4000 (0).
- R2: An opcode missing from the table completes with return code 0x0003, reports the supplied input length as the output length, and never starts the handler.
- R3: A supported opcode whose supplied length differs from its table length completes with return code 0x0016, reports the supplied length, and never starts the handler.
- R4: On completion, status word bits [15:0] (word address 2) hold the return code and bits [31:16] read zero. The command word reads as output length in [31:16] with zero group and index.
- R5: A command that passes both checks raises `hnd_start` for exactly one cycle, with `hnd_opcode` and `hnd_in_len` taken from the command word. The code and length returned with `hnd_done` are reported unchanged.
- R6: Control word (word address 0) bit 0 is the doorbell. Writing 1 there while idle starts a command. The doorbell reads 1 until the result words are final and is cleared two cycles after they are written.
- R7: A handler output length above the payload buffer size (PL_WORDS*4 bytes) completes with return code 0x0004 and output length 0. A length equal to the buffer size is accepted.
- R8: Control word bit 1 reads 1 while a command is in progress. While it is set, host writes to the control and command words have no effect, so a second doorbell starts nothing.
- R9: Payload word i is at host word address 64+i and at handler address i. The handler sees host-written data and may write words back for the host to read.
- R10: After reset, the control, command and status words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | REG_AW | Host word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from reg_addr |
| hnd_start | output | 1 | One-cycle pulse launching the handler |
| hnd_opcode | output | 16 | Opcode of the command being run |
| hnd_in_len | output | 16 | Input payload length in bytes |
| hnd_done | input | 1 | Handler completion strobe |
| hnd_ret | input | 16 | Handler return code |
| hnd_out_len | input | 16 | Handler output length in bytes |
| hnd_pl_addr | input | PL_AW | Handler payload word address |
| hnd_pl_we | input | 1 | Handler payload write strobe, honoured only while the handler runs |
| hnd_pl_wdata | input | 32 | Handler payload write data |
| hnd_pl_rdata | output | 32 | Handler payload read data |

## Verification
The bench targets the two rejection paths with near-miss opcodes: an unknown group, and an index one past the last supported one. It also uses a known opcode with the wrong length. A design that reused the table length, or that zeroed the reported length, would give the wrong command word, and one that started the handler anyway would raise the bench's count of handler starts. Handler output lengths one byte either side of the buffer size probe the internal-error limit, where an off-by-one comparison flips the return code. A second doorbell and a command-word write are sent while a command runs. A design that did not ignore them would either run an extra handler or report an opcode or length taken from the intruding write.

// File: rtl/mbox_pkg.sv
// Package: shared constants and types for the mailbox dispatcher.
// Assumes payload lengths and return codes both fit in 16 bits.
package mbox_pkg;

    localparam int LEN_W  = 16;
    localparam int CODE_W = 16;

    // Return codes written to the status word
    localparam logic [CODE_W-1:0] RC_SUCCESS     = 16'h0000;
    localparam logic [CODE_W-1:0] RC_BAD_INPUT   = 16'h0002;
    localparam logic [CODE_W-1:0] RC_UNSUPPORTED = 16'h0003;
    localparam logic [CODE_W-1:0] RC_INTERNAL    = 16'h0004;
    localparam logic [CODE_W-1:0] RC_BAD_LENGTH  = 16'h0016;

    // Supported opcode table: opcode and exact required input length
    localparam int N_OPS = 9;
    localparam logic [15:0] OP_CODES [N_OPS] = '{
        16'h0100, 16'h0101, 16'h0102, 16'h0103,
        16'h0300, 16'h0301, 16'h0400, 16'h0401, 16'h4000
    };
    localparam logic [LEN_W-1:0] OP_IN_LEN [N_OPS] = '{
        16'd1, 16'd2, 16'd0, 16'd4,
        16'd0, 16'd8, 16'd0, 16'd24, 16'd0
    };

    // Register word offsets
    localparam int REG_CTRL = 0;
    localparam int REG_CMD  = 1;
    localparam int REG_STS  = 2;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CHECK,
        SEQ_EXEC,
        SEQ_POST,
        SEQ_RING
    } seq_state_e;

endpackage

// File: rtl/mbox_op_table.sv
// Module: opcode lookup. Compares the opcode with every table entry in
// parallel and returns a hit flag and the required input length.
// Assumes table entries are unique.
module mbox_op_table
    import mbox_pkg::*;
(
    input  logic [15:0]      opcode,
    output logic             hit,
    output logic [LEN_W-1:0] req_len
);

    logic [N_OPS-1:0] match;

    // One comparator per table entry
    for (genvar i = 0; i < N_OPS; i++) begin : g_entry
        assign match[i] = (opcode == OP_CODES[i]);
    end

    // Reduce the match vector to a hit flag and the selected length
    always_comb begin
        req_len = '0;
        for (int i = 0; i < N_OPS; i++) begin
            if (match[i]) req_len = req_len | OP_IN_LEN[i];
        end
        hit = |match;
    end

endmodule

// File: rtl/mbox_payload_ram.sv
// Module: payload buffer with a host port and a handler port, both with
// combinational read. Assumes WORDS is a power of two and that the
// caller never enables both writes to the same word; the handler wins.
module mbox_payload_ram #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          hnd_we,
    input  logic [AW-1:0] hnd_addr,
    input  logic [DW-1:0] hnd_wdata,
    output logic [DW-1:0] hnd_rdata
);

    logic [DW-1:0] mem [WORDS];

    // Word storage with handler-priority writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (hnd_we) begin
            mem[hnd_addr] <= hnd_wdata;
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    // Combinational read ports
    assign host_rdata = mem[host_addr];
    assign hnd_rdata  = mem[hnd_addr];

endmodule

// File: rtl/mbox_sequencer.sv
// Module: command sequencer. Walks one command through check, handler
// execution, result write-back and doorbell release. Assumes ring is only
// raised while idle and that the command word is frozen while busy.
module mbox_sequencer
    import mbox_pkg::*;
#(
    parameter int PL_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring,
    input  logic              hit,
    input  logic              len_ok,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              done,
    input  logic [CODE_W-1:0] ret,
    input  logic [LEN_W-1:0]  out_len,
    output logic              busy,
    output logic              db,
    output logic              start,
    output logic              exec,
    output logic              wb_en,
    output logic [CODE_W-1:0] wb_code,
    output logic [LEN_W-1:0]  wb_len
);

    localparam logic [LEN_W:0] LEN_LIMIT = (LEN_W+1)'(PL_BYTES);

    seq_state_e state;
    logic       too_long;

    assign too_long = ({1'b0, out_len} > LEN_LIMIT);

    // State, doorbell, start pulse and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            db      <= 1'b0;
            start   <= 1'b0;
            wb_code <= '0;
            wb_len  <= '0;
        end else begin
            start <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (ring) begin
                        db    <= 1'b1;
                        state <= SEQ_CHECK;
                    end
                end
                SEQ_CHECK: begin
                    if (!hit) begin
                        wb_code <= RC_UNSUPPORTED;
                        wb_len  <= in_len;
                        state   <= SEQ_POST;
                    end else if (!len_ok) begin
                        wb_code <= RC_BAD_LENGTH;
                        wb_len  <= in_len;
                        state   <= SEQ_POST;
                    end else begin
                        start <= 1'b1;
                        state <= SEQ_EXEC;
                    end
                end
                SEQ_EXEC: begin
                    if (done) begin
                        if (too_long) begin
                            wb_code <= RC_INTERNAL;
                            wb_len  <= '0;
                        end else begin
                            wb_code <= ret;
                            wb_len  <= out_len;
                        end
                        state <= SEQ_POST;
                    end
                end
                SEQ_POST: begin
                    state <= SEQ_RING;
                end
                SEQ_RING: begin
                    db    <= 1'b0;
                    state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Decoded phase flags
    assign busy  = (state != SEQ_IDLE);
    assign exec  = (state == SEQ_EXEC);
    assign wb_en = (state == SEQ_POST);

endmodule

// File: rtl/mbox_dispatch.sv
// Module: mailbox dispatcher top. Holds the control, command and status
// words, decodes the host register window and wires the opcode table,
// sequencer and payload buffer together. Assumes PL_WORDS is a power of
// two no larger than half the register window.
module mbox_dispatch
    import mbox_pkg::*;
#(
    parameter int  PL_WORDS = 16,
    parameter int  REG_AW   = 7,
    localparam int PL_AW    = $clog2(PL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hnd_start,
    output logic [15:0]       hnd_opcode,
    output logic [15:0]       hnd_in_len,
    input  logic              hnd_done,
    input  logic [15:0]       hnd_ret,
    input  logic [15:0]       hnd_out_len,
    input  logic [PL_AW-1:0]  hnd_pl_addr,
    input  logic              hnd_pl_we,
    input  logic [31:0]       hnd_pl_wdata,
    output logic [31:0]       hnd_pl_rdata
);

    localparam int PL_BYTES = PL_WORDS * 4;
    localparam int IDX_W    = REG_AW - 1;
    localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(REG_CTRL);
    localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(REG_CMD);
    localparam logic [REG_AW-1:0] A_STS  = REG_AW'(REG_STS);

    logic [31:0]       cmd_q;
    logic [31:0]       sts_q;
    logic              busy;
    logic              db_q;
    logic              exec_phase;
    logic              wb_en;
    logic [CODE_W-1:0] wb_code;
    logic [LEN_W-1:0]  wb_len;
    logic              tbl_hit;
    logic [LEN_W-1:0]  tbl_len;
    logic              ring;
    logic              cmd_wr_try;
    logic              pl_sel;
    logic [IDX_W-1:0]  pl_idx;
    logic [31:0]       pl_host_rdata;

    // Host write decode
    assign cmd_wr_try = reg_we && (reg_addr == A_CMD);
    assign ring       = reg_we && (reg_addr == A_CTRL) && reg_wdata[0] && !busy;
    assign pl_idx     = reg_addr[IDX_W-1:0];
    assign pl_sel     = reg_addr[REG_AW-1] &&
                        ({{(32-IDX_W){1'b0}}, pl_idx} < PL_WORDS);

    // Opcode and length presented to table and handler
    assign hnd_opcode = cmd_q[15:0];
    assign hnd_in_len = cmd_q[31:16];

    mbox_op_table u_table (
        .opcode  (hnd_opcode),
        .hit     (tbl_hit),
        .req_len (tbl_len)
    );

    mbox_sequencer #(
        .PL_BYTES (PL_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ring    (ring),
        .hit     (tbl_hit),
        .len_ok  (hnd_in_len == tbl_len),
        .in_len  (hnd_in_len),
        .done    (hnd_done),
        .ret     (hnd_ret),
        .out_len (hnd_out_len),
        .busy    (busy),
        .db      (db_q),
        .start   (hnd_start),
        .exec    (exec_phase),
        .wb_en   (wb_en),
        .wb_code (wb_code),
        .wb_len  (wb_len)
    );

    mbox_payload_ram #(
        .WORDS (PL_WORDS),
        .DW    (32)
    ) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (reg_we && pl_sel && !busy),
        .host_addr  (pl_idx[PL_AW-1:0]),
        .host_wdata (reg_wdata),
        .host_rdata (pl_host_rdata),
        .hnd_we     (hnd_pl_we && exec_phase),
        .hnd_addr   (hnd_pl_addr),
        .hnd_wdata  (hnd_pl_wdata),
        .hnd_rdata  (hnd_pl_rdata)
    );

    // Command word: host writes while idle, result write-back on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wb_en) begin
            cmd_q <= {wb_len, 16'h0000};
        end else if (cmd_wr_try && !busy) begin
            cmd_q <= reg_wdata;
        end
    end

    // Status word: return code only, rewritten on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else if (wb_en) begin
            sts_q <= {16'h0000, wb_code};
        end
    end

    // Host read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)     reg_rdata = {30'd0, busy, db_q};
        else if (reg_addr == A_CMD) reg_rdata = cmd_q;
        else if (reg_addr == A_STS) reg_rdata = sts_q;
        else if (pl_sel)            reg_rdata = pl_host_rdata;
    end

endmodule

// File: rtl/mbox_dispatch_chk.sv
// Module: protocol checker for the mailbox dispatcher, bound into the top.
// Assumes it observes the top's internal control and result words.
module mbox_dispatch_chk #(
    parameter int PL_BYTES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hnd_start,
    input logic        hnd_done,
    input logic [15:0] hnd_out_len,
    input logic [15:0] hnd_in_len,
    input logic        tbl_hit,
    input logic [15:0] tbl_len,
    input logic        db_q,
    input logic        busy,
    input logic        wb_en,
    input logic        exec_phase,
    input logic        cmd_wr_try,
    input logic [31:0] cmd_q,
    input logic [31:0] sts_q
);

    localparam logic [16:0] LIMIT = 17'(PL_BYTES);

    AST_START_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> tbl_hit); // R2

    AST_START_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> (hnd_in_len == tbl_len)); // R3

    AST_DB_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(db_q) |-> $past(wb_en, 2)); // R6

    AST_BUSY_FREEZES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr_try && !wb_en) |=> $stable(cmd_q)); // R8

    AST_OVERSIZE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_phase && hnd_done && ({1'b0, hnd_out_len} > LIMIT))
        |=> ##1 (sts_q == 32'h0000_0004 && cmd_q == 32'h0)); // R7

endmodule

bind mbox_dispatch mbox_dispatch_chk #(
    .PL_BYTES (PL_WORDS * 4)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hnd_start   (hnd_start),
    .hnd_done    (hnd_done),
    .hnd_out_len (hnd_out_len),
    .hnd_in_len  (hnd_in_len),
    .tbl_hit     (tbl_hit),
    .tbl_len     (tbl_len),
    .db_q        (db_q),
    .busy        (busy),
    .wb_en       (wb_en),
    .exec_phase  (exec_phase),
    .cmd_wr_try  (cmd_wr_try),
    .cmd_q       (cmd_q),
    .sts_q       (sts_q)
);

// File: tb/test_mbox_dispatch.sv
// Bench: scoreboard-based test of the mailbox dispatcher with a handler stub.
module test_mbox_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int PL_WORDS   = 16;
    localparam int REG_AW     = 7;
    localparam int PL_AW      = 4;
    localparam logic [REG_AW-1:0] A_CTRL = 7'd0;
    localparam logic [REG_AW-1:0] A_CMD  = 7'd1;
    localparam logic [REG_AW-1:0] A_STS  = 7'd2;
    localparam logic [REG_AW-1:0] A_PL0  = 7'd64;
    localparam logic [REG_AW-1:0] A_PL1  = 7'd65;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              hnd_start;
    logic [15:0]       hnd_opcode;
    logic [15:0]       hnd_in_len;
    logic              hnd_done = 1'b0;
    logic [15:0]       hnd_ret = '0;
    logic [15:0]       hnd_out_len = '0;
    logic [PL_AW-1:0]  hnd_pl_addr = '0;
    logic              hnd_pl_we = 1'b0;
    logic [31:0]       hnd_pl_wdata = '0;
    logic [31:0]       hnd_pl_rdata;

    typedef struct {
        string       tag;
        logic [31:0] cmd;
        logic [31:0] sts;
    } sb_item_t;

    sb_item_t exp_q[$];
    sb_item_t act_q[$];
    sb_item_t e_item, a_item;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0;
    int stub_delay = 2;
    logic [15:0] stub_ret = '0;
    logic [15:0] stub_len = '0;
    logic [15:0] seen_op = '0;
    logic [15:0] seen_len = '0;
    logic [31:0] seen_word = '0;

    mbox_dispatch #(
        .PL_WORDS (PL_WORDS),
        .REG_AW   (REG_AW)
    ) i_mbox_dispatch (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .hnd_start    (hnd_start),
        .hnd_opcode   (hnd_opcode),
        .hnd_in_len   (hnd_in_len),
        .hnd_done     (hnd_done),
        .hnd_ret      (hnd_ret),
        .hnd_out_len  (hnd_out_len),
        .hnd_pl_addr  (hnd_pl_addr),
        .hnd_pl_we    (hnd_pl_we),
        .hnd_pl_wdata (hnd_pl_wdata),
        .hnd_pl_rdata (hnd_pl_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver: pushes the expected result, runs one command, collects outputs
    task automatic run_cmd(input logic [7:0] grp, input logic [7:0] idx,
                           input logic [15:0] len, input logic [15:0] sret,
                           input logic [15:0] slen, input int sdly,
                           input logic [15:0] ecode, input logic [15:0] elen,
                           input bit poke, input string tag);
        logic [31:0] d, c, s;
        stub_ret   = sret;
        stub_len   = slen;
        stub_delay = sdly;
        exp_q.push_back('{tag, {elen, 16'h0000}, {16'h0000, ecode}});
        reg_wr(A_CMD, {len, grp, idx});
        reg_wr(A_CTRL, 32'h1);
        if (poke) begin
            reg_wr(A_CMD, 32'hFFFF_0200);
            reg_wr(A_CTRL, 32'h1);
            reg_rd(A_CTRL, d);
            check("R8 busy and doorbell read back while running", d, 32'h3);
        end
        do reg_rd(A_CTRL, d); while (d[0]);
        reg_rd(A_CMD, c);
        reg_rd(A_STS, s);
        act_q.push_back('{tag, c, s});
        repeat (2) @(negedge clk);
    endtask

    // Handler stub: reacts to start, touches the payload, then answers
    initial begin
        forever begin
            @(negedge clk);
            if (hnd_start === 1'b1) begin
                n_start++;
                seen_op  = hnd_opcode;
                seen_len = hnd_in_len;
                hnd_pl_addr = '0;
                #1;
                seen_word    = hnd_pl_rdata;
                hnd_pl_addr  = PL_AW'(1);
                hnd_pl_we    = 1'b1;
                hnd_pl_wdata = 32'hC0DE_0001;
                @(negedge clk);
                hnd_pl_we = 1'b0;
                repeat (stub_delay) @(negedge clk);
                hnd_done    = 1'b1;
                hnd_ret     = stub_ret;
                hnd_out_len = stub_len;
                @(negedge clk);
                hnd_done = 1'b0;
            end
        end
    end

    // Monitor: pops expected and actual items and compares them
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0 && act_q.size() > 0) begin
                e_item = exp_q.pop_front();
                a_item = act_q.pop_front();
                check({e_item.tag, " command word"}, a_item.cmd, e_item.cmd);
                check({e_item.tag, " status word"}, a_item.sts, e_item.sts);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int starts;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        reg_rd(A_CTRL, d); check("R10 control after reset", d, 32'h0);
        reg_rd(A_CMD, d);  check("R10 command after reset", d, 32'h0);
        reg_rd(A_STS, d);  check("R10 status after reset", d, 32'h0);

        // R9 host fills payload, handler reads it and writes word 1
        reg_wr(A_PL0, 32'hA5A5_0001);
        run_cmd(8'h03, 8'h00, 16'd0, 16'h0000, 16'd8, 2, 16'h0000, 16'd8, 0,
                "R1 R4 R5 timestamp read");
        check("R5 opcode seen by handler", {16'h0, seen_op}, 32'h0000_0300);
        check("R5 length seen by handler", {16'h0, seen_len}, 32'h0);
        check("R9 handler reads host payload", seen_word, 32'hA5A5_0001);
        reg_rd(A_PL1, d);
        check("R9 host reads handler payload", d, 32'hC0DE_0001);

        // R2 unknown group, and index beyond a known group
        starts = n_start;
        run_cmd(8'h02, 8'h00, 16'd5, 16'h0, 16'd0, 2, 16'h0003, 16'd5, 0,
                "R2 unknown group");
        run_cmd(8'h01, 8'h04, 16'd0, 16'h0, 16'd0, 2, 16'h0003, 16'd0, 0,
                "R2 index past table");
        check("R2 handler never started", 32'(n_start - starts), 32'd0);

        // R3 length mismatch
        starts = n_start;
        run_cmd(8'h03, 8'h01, 16'd4, 16'h0, 16'd0, 2, 16'h0016, 16'd4, 0,
                "R3 wrong input length");
        check("R3 handler never started", 32'(n_start - starts), 32'd0);
        run_cmd(8'h03, 8'h01, 16'd8, 16'h0, 16'd0, 2, 16'h0000, 16'd0, 0,
                "R3 exact input length accepted");

        // R7 output length limit
        run_cmd(8'h40, 8'h00, 16'd0, 16'h0, 16'd65, 2, 16'h0004, 16'd0, 0,
                "R7 output one byte too long");
        run_cmd(8'h40, 8'h00, 16'd0, 16'h0, 16'd64, 2, 16'h0000, 16'd64, 0,
                "R7 output fills buffer");

        // R5 handler code passes through
        run_cmd(8'h04, 8'h01, 16'd24, 16'h0002, 16'd0, 3, 16'h0002, 16'd0, 0,
                "R5 handler error code");

        // R8 writes while busy are ignored
        starts = n_start;
        run_cmd(8'h01, 8'h03, 16'd4, 16'h0, 16'd4, 8, 16'h0000, 16'd4, 1,
                "R8 writes during run ignored");
        check("R8 single handler start", 32'(n_start - starts), 32'd1);
        check("R8 opcode unaffected", {16'h0, seen_op}, 32'h0000_0103);
        reg_rd(A_CTRL, d);
        check("R6 R8 idle after completion", d, 32'h0);

        run_cmd(8'h01, 8'h00, 16'd1, 16'h0, 16'd32, 1, 16'h0000, 16'd32, 0,
                "R1 R6 event record read");

        while (exp_q.size() > 0) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule